// File: doc/BRIEF.md
# Multi-Bank SDRAM Write Sequencer

This block turns write requests into the command, address and data stream that a four-bank synchronous DRAM expects. Each request names a bank, a row, a start column, an auto-precharge flag and a full burst of data. The sequencer opens the row when needed, closes a different open row first, and then issues the write with the first data word. It keeps a separate state and timer for every bank. Activates and precharges to other banks can therefore slip in while a burst is still on the data bus, and a bank that is closing itself after an auto-precharge write does not hold up the others.

Requests use a valid/ready handshake. A request stays on the inputs until the cycle in which it is accepted, and acceptance means its write command has been chosen. The command, bank, address and data outputs are registered, so the command decided in one cycle appears on the pins in the next. On the command bus, {ras_n, cas_n, we_n} takes the values NOP = 111, ACT = 011, WRITE = 100 and PRE = 010.

Top module: `sdw_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it: `cmd_o` is NOP (111), `dq_oe` is 0 and `req_ready` is 0. After reset every bank is closed, so the first request to any bank starts with an ACT.
- R2: Commands are encoded on `cmd_o` as NOP=111, ACT=011, WRITE=100 and PRE=010. `ba_o` carries the target bank of every non-NOP command. An ACT carries the row on `addr_o`, zero-extended.
- R3: A request to a closed bank produces an ACT. The WRITE to that bank comes no earlier than T_RCD cycles after the ACT, and exactly T_RCD cycles after it when nothing else blocks the write.
- R4: The first burst word (`req_data` bits DQ_W-1:0) is on `dq_o` in the same cycle as the WRITE. Word k (bits k*DQ_W upward) follows k cycles later. `dq_oe` is high for exactly those BL cycles, and bursts never overlap.
- R5: On a WRITE, `addr_o[COL_W-1:0]` is the start column, `addr_o[AP_BIT]` (bit 10 by default) is the auto-precharge flag, and every other address bit is 0. A PRE drives `addr_o[AP_BIT]` low.
- R6: A request whose bank has the same row open issues its WRITE without a new ACT. Back-to-back writes are spaced exactly BL cycles apart.
- R7: A request whose bank has a different row open issues PRE, then ACT, then WRITE. The PRE comes at least T_WR cycles after the last data word of the previous write to that bank, the ACT exactly T_RP cycles after the PRE, and the WRITE T_RCD cycles after the ACT.
- R8: After a write with auto-precharge, no command goes to that bank until T_WR+T_RP cycles after its last data word. The next ACT to it is issued at exactly that cycle when a request is waiting.
- R9: While one bank has a burst on the bus or is recovering, a request to another bank issues its ACT at once, so that bank's row opening overlaps the earlier burst.
- R10: `cmd_o` is NOP in every cycle in which no command is issued, and every non-NOP command follows a cycle with `req_valid` high. `dq_oe` is low and `dq_o` is zero outside write bursts.
- R11: `req_ready` is high only with `req_valid`, and only in the cycle that decides the WRITE; that WRITE appears on `cmd_o` in the next cycle. A stalled request sees `req_ready` low until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_bank | input | BA_W (2) | Target bank |
| req_row | input | ROW_W (12) | Target row |
| req_col | input | COL_W (9) | Burst start column |
| req_auto_pre | input | 1 | Close the row after this write |
| req_data | input | BL*DQ_W (64) | Burst words, word 0 in the low bits |
| cmd_o | output | 3 | {ras_n, cas_n, we_n} command |
| ba_o | output | BA_W (2) | Bank address |
| addr_o | output | ADDR_W (12) | Row, or column with the auto-precharge bit |
| dq_o | output | DQ_W (16) | Write data |
| dq_oe | output | 1 | Data output enable |

## Verification
All outputs are registered, so a command decided in cycle d shows on `cmd_o` in cycle d+1. The first data word shows in that same cycle, and word k shows k cycles later. The bench keeps a table of expected commands, each with its cycle offset from the first ACT. These offsets were worked out from the T_RCD, T_WR, T_RP and BL windows, starting each request in the cycle after the previous acceptance. The bench samples every output at the falling edge, so each registered change is seen in the cycle it is due. The directed tests count falling edges from the cycle a request appears: `req_ready` is due two cycles later, and the ACT, WRITE and end of the burst each at their own fixed offset.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

   // {ras_n, cas_n, we_n}
   typedef enum logic [2:0] {
      CMD_NOP = 3'b111,
      CMD_ACT = 3'b011,
      CMD_WR  = 3'b100,
      CMD_PRE = 3'b010
   } sdw_cmd_e;

   typedef enum logic [1:0] {
      BK_IDLE = 2'd0,
      BK_OPEN = 2'd1,
      BK_APRE = 2'd2
   } sdw_bank_st_e;

endpackage

// File: rtl/sdw_bank.sv
// Per-bank row state with a command timer (ACT/WRITE gate) and a
// write-recovery timer (PRE gate).
module sdw_bank
   import sdw_pkg::*;
#(
   parameter int ROW_W = 12,
   parameter int BL    = 4,
   parameter int T_RCD = 2,
   parameter int T_RP  = 2,
   parameter int T_WR  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             do_act,
   input  logic             do_wr,
   input  logic             do_pre,
   input  logic             wr_ap,
   input  logic [ROW_W-1:0] act_row,
   output sdw_bank_st_e     st,
   output logic [ROW_W-1:0] open_row,
   output logic             cnt_zero,
   output logic             rec_zero
);

   localparam int LD_RCD = T_RCD - 1;
   localparam int LD_RP  = T_RP - 1;
   localparam int LD_WR  = BL + T_WR - 2;
   localparam int LD_AP  = BL + T_WR + T_RP - 2;
   localparam int CNT_W  = $clog2(LD_AP + 2);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] rec_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= BK_IDLE;
         open_row <= '0;
         cnt_q    <= '0;
         rec_q    <= '0;
      end else begin
         if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
         if (rec_q != '0) rec_q <= rec_q - 1'b1;
         if (do_act) begin
            st       <= BK_OPEN;
            open_row <= act_row;
            cnt_q    <= CNT_W'(LD_RCD);
         end else if (do_wr) begin
            rec_q <= CNT_W'(LD_WR);
            if (wr_ap) begin
               st    <= BK_APRE;
               cnt_q <= CNT_W'(LD_AP);
            end
         end else if (do_pre) begin
            st    <= BK_IDLE;
            cnt_q <= CNT_W'(LD_RP);
         end else if (st == BK_APRE && cnt_q == '0) begin
            st <= BK_IDLE;
         end
      end
   end

   assign cnt_zero = (cnt_q == '0);
   assign rec_zero = (rec_q == '0);

endmodule

// File: rtl/sdw_burst.sv
// Registered write-data burst engine.
module sdw_burst #(
   parameter int DQ_W = 16,
   parameter int BL   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [BL*DQ_W-1:0] data,
   output logic [DQ_W-1:0]  dq_o,
   output logic             dq_oe,
   output logic             busy
);

   generate
      if (BL == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               dq_o  <= '0;
               dq_oe <= 1'b0;
            end else begin
               dq_o  <= start ? data : '0;
               dq_oe <= start;
            end
         end
         assign busy = 1'b0;
      end else begin : g_multi
         localparam int LEFT_W = $clog2(BL);
         localparam int SH_W   = (BL - 1) * DQ_W;

         logic [SH_W-1:0]   sh_q;
         logic [LEFT_W-1:0] left_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               dq_o   <= '0;
               dq_oe  <= 1'b0;
               sh_q   <= '0;
               left_q <= '0;
            end else if (start) begin
               dq_o   <= data[DQ_W-1:0];
               dq_oe  <= 1'b1;
               sh_q   <= data[BL*DQ_W-1:DQ_W];
               left_q <= LEFT_W'(BL - 1);
            end else if (left_q != '0) begin
               dq_o   <= sh_q[DQ_W-1:0];
               dq_oe  <= 1'b1;
               sh_q   <= sh_q >> DQ_W;
               left_q <= left_q - 1'b1;
            end else begin
               dq_o  <= '0;
               dq_oe <= 1'b0;
            end
         end
         assign busy = (left_q != '0);
      end
   endgenerate

endmodule

// File: rtl/sdw_sched.sv
// Picks one command per cycle for the pending request and registers the
// command bus.
module sdw_sched
   import sdw_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 12,
   parameter int COL_W     = 9,
   parameter int ADDR_W    = 12,
   parameter int AP_BIT    = 10,
   localparam int BA_W     = $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [BA_W-1:0]      req_bank,
   input  logic [ROW_W-1:0]     req_row,
   input  logic [COL_W-1:0]     req_col,
   input  logic                 req_ap,
   input  sdw_bank_st_e         bk_st [NUM_BANKS],
   input  logic [ROW_W-1:0]     bk_row [NUM_BANKS],
   input  logic [NUM_BANKS-1:0] bk_cnt_zero,
   input  logic [NUM_BANKS-1:0] bk_rec_zero,
   input  logic                 burst_busy,
   output logic                 go_act,
   output logic                 go_wr,
   output logic                 go_pre,
   output logic                 req_ready,
   output logic [2:0]           cmd_o,
   output logic [BA_W-1:0]      ba_o,
   output logic [ADDR_W-1:0]    addr_o
);

   sdw_bank_st_e      t_st;
   logic              t_row_hit;
   logic              t_cnt_zero;
   logic              t_rec_zero;
   sdw_cmd_e          nxt_cmd;
   logic [ADDR_W-1:0] nxt_addr;

   always_comb begin
      t_st       = bk_st[req_bank];
      t_row_hit  = (bk_row[req_bank] == req_row);
      t_cnt_zero = bk_cnt_zero[req_bank];
      t_rec_zero = bk_rec_zero[req_bank];
      nxt_cmd    = CMD_NOP;
      if (req_valid) begin
         unique case (t_st)
            BK_IDLE, BK_APRE: begin
               if (t_cnt_zero) nxt_cmd = CMD_ACT;
            end
            BK_OPEN: begin
               if (t_row_hit) begin
                  if (t_cnt_zero && !burst_busy) nxt_cmd = CMD_WR;
               end else if (t_cnt_zero && t_rec_zero) begin
                  nxt_cmd = CMD_PRE;
               end
            end
            default: nxt_cmd = CMD_NOP;
         endcase
      end
   end

   always_comb begin
      nxt_addr = '0;
      if (nxt_cmd == CMD_ACT) begin
         nxt_addr = ADDR_W'(req_row);
      end else if (nxt_cmd == CMD_WR) begin
         nxt_addr         = ADDR_W'(req_col);
         nxt_addr[AP_BIT] = req_ap;
      end
   end

   assign go_act    = (nxt_cmd == CMD_ACT);
   assign go_wr     = (nxt_cmd == CMD_WR);
   assign go_pre    = (nxt_cmd == CMD_PRE);
   assign req_ready = go_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_o  <= CMD_NOP;
         ba_o   <= '0;
         addr_o <= '0;
      end else begin
         cmd_o  <= nxt_cmd;
         ba_o   <= (nxt_cmd == CMD_NOP) ? '0 : req_bank;
         addr_o <= nxt_addr;
      end
   end

endmodule

// File: rtl/sdw_ctrl.sv
module sdw_ctrl
   import sdw_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 12,
   parameter int COL_W     = 9,
   parameter int ADDR_W    = 12,
   parameter int AP_BIT    = 10,
   parameter int DQ_W      = 16,
   parameter int BL        = 4,
   parameter int T_RCD     = 2,
   parameter int T_RP      = 2,
   parameter int T_WR      = 1,
   localparam int BA_W     = $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [BA_W-1:0]      req_bank,
   input  logic [ROW_W-1:0]     req_row,
   input  logic [COL_W-1:0]     req_col,
   input  logic                 req_auto_pre,
   input  logic [BL*DQ_W-1:0]   req_data,
   output logic [2:0]           cmd_o,
   output logic [BA_W-1:0]      ba_o,
   output logic [ADDR_W-1:0]    addr_o,
   output logic [DQ_W-1:0]      dq_o,
   output logic                 dq_oe
);

   generate
      if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
         $error("sdw_ctrl: NUM_BANKS must be a power of two >= 2");
      end
      if (ROW_W > ADDR_W || AP_BIT >= ADDR_W || COL_W > AP_BIT) begin : g_bad_addr
         $error("sdw_ctrl: row, column and auto-precharge bit must fit the address");
      end
      if (T_RCD < 1 || T_RP < 1 || T_WR < 1 || BL < 1) begin : g_bad_timing
         $error("sdw_ctrl: timing parameters and BL must be at least 1");
      end
   endgenerate

   sdw_bank_st_e         bk_st  [NUM_BANKS];
   logic [ROW_W-1:0]     bk_row [NUM_BANKS];
   logic [NUM_BANKS-1:0] bk_cnt_zero;
   logic [NUM_BANKS-1:0] bk_rec_zero;
   logic                 go_act;
   logic                 go_wr;
   logic                 go_pre;
   logic                 burst_busy;

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         logic sel;
         assign sel = (req_bank == BA_W'(b));

         sdw_bank #(
            .ROW_W (ROW_W),
            .BL    (BL),
            .T_RCD (T_RCD),
            .T_RP  (T_RP),
            .T_WR  (T_WR)
         ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .do_act   (go_act && sel),
            .do_wr    (go_wr && sel),
            .do_pre   (go_pre && sel),
            .wr_ap    (req_auto_pre),
            .act_row  (req_row),
            .st       (bk_st[b]),
            .open_row (bk_row[b]),
            .cnt_zero (bk_cnt_zero[b]),
            .rec_zero (bk_rec_zero[b])
         );
      end
   endgenerate

   sdw_sched #(
      .NUM_BANKS (NUM_BANKS),
      .ROW_W     (ROW_W),
      .COL_W     (COL_W),
      .ADDR_W    (ADDR_W),
      .AP_BIT    (AP_BIT)
   ) u_sched (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_bank    (req_bank),
      .req_row     (req_row),
      .req_col     (req_col),
      .req_ap      (req_auto_pre),
      .bk_st       (bk_st),
      .bk_row      (bk_row),
      .bk_cnt_zero (bk_cnt_zero),
      .bk_rec_zero (bk_rec_zero),
      .burst_busy  (burst_busy),
      .go_act      (go_act),
      .go_wr       (go_wr),
      .go_pre      (go_pre),
      .req_ready   (req_ready),
      .cmd_o       (cmd_o),
      .ba_o        (ba_o),
      .addr_o      (addr_o)
   );

   sdw_burst #(
      .DQ_W (DQ_W),
      .BL   (BL)
   ) u_burst (
      .clk   (clk),
      .rst_n (rst_n),
      .start (go_wr),
      .data  (req_data),
      .dq_o  (dq_o),
      .dq_oe (dq_oe),
      .busy  (burst_busy)
   );

endmodule

// File: rtl/sdw_ctrl_chk.sv
// Protocol checker: watches the command and data pins and measures every
// per-bank window with its own saturating counters.
module sdw_ctrl_chk
   import sdw_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ADDR_W    = 12,
   parameter int AP_BIT    = 10,
   parameter int BL        = 4,
   parameter int T_RCD     = 2,
   parameter int T_RP      = 2,
   parameter int T_WR      = 1,
   localparam int BA_W     = $clog2(NUM_BANKS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [2:0]        cmd_o,
   input logic [BA_W-1:0]   ba_o,
   input logic [ADDR_W-1:0] addr_o,
   input logic              dq_oe
);

   localparam int          WIN_REC = BL - 1 + T_WR;
   localparam int          WIN_AP  = BL - 1 + T_WR + T_RP;
   localparam logic [7:0]  SAT     = 8'hFF;

   generate
      if (WIN_AP >= 250 || T_RCD >= 250) begin : g_bad_win
         $error("sdw_ctrl_chk: timing windows exceed the checker counters");
      end
   endgenerate

   logic is_act, is_wr, is_pre;
   assign is_act = (cmd_o == CMD_ACT);
   assign is_wr  = (cmd_o == CMD_WR);
   assign is_pre = (cmd_o == CMD_PRE);

   logic [7:0] beats_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                beats_q <= '0;
      else if (is_wr)            beats_q <= 8'(BL - 1);
      else if (beats_q != '0)    beats_q <= beats_q - 1'b1;
   end

   assert_oe_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe == (is_wr || beats_q != '0));

   assert_no_burst_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      is_wr |-> beats_q == '0);

   assert_accept_to_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> is_wr);

   assert_ready_needs_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> req_valid);

   assert_cmd_needs_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o != CMD_NOP) |-> $past(req_valid));

   assert_pre_ap_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      is_pre |-> !addr_o[AP_BIT]);

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bk
         logic       hit;
         logic [7:0] since_act, since_pre, since_wr;
         logic       ap_last, is_open;

         assign hit = (ba_o == BA_W'(b));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               since_act <= SAT;
               since_pre <= SAT;
               since_wr  <= SAT;
               ap_last   <= 1'b0;
               is_open   <= 1'b0;
            end else begin
               since_act <= (is_act && hit) ? 8'd1 : (since_act == SAT ? SAT : since_act + 1'b1);
               since_pre <= (is_pre && hit) ? 8'd1 : (since_pre == SAT ? SAT : since_pre + 1'b1);
               since_wr  <= (is_wr  && hit) ? 8'd1 : (since_wr  == SAT ? SAT : since_wr  + 1'b1);
               if (is_wr && hit) ap_last <= addr_o[AP_BIT];
               if (is_act && hit)
                  is_open <= 1'b1;
               else if ((is_pre && hit) || (is_wr && hit && addr_o[AP_BIT]))
                  is_open <= 1'b0;
            end
         end

         assert_wr_after_rcd_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (is_wr && hit) |-> since_act >= 8'(T_RCD));

         assert_wr_open_row_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (is_wr && hit) |-> is_open);

         assert_pre_after_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (is_pre && hit) |-> since_wr >= 8'(WIN_REC));

         assert_act_after_rp_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (is_act && hit) |-> since_pre >= 8'(T_RP));

         assert_ap_lockout_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ((is_act || is_wr || is_pre) && hit && ap_last) |-> since_wr >= 8'(WIN_AP));
      end
   endgenerate

endmodule

bind sdw_ctrl sdw_ctrl_chk #(
   .NUM_BANKS (NUM_BANKS),
   .ADDR_W    (ADDR_W),
   .AP_BIT    (AP_BIT),
   .BL        (BL),
   .T_RCD     (T_RCD),
   .T_RP      (T_RP),
   .T_WR      (T_WR)
) u_sdw_ctrl_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .cmd_o     (cmd_o),
   .ba_o      (ba_o),
   .addr_o    (addr_o),
   .dq_oe     (dq_oe)
);

// File: tb/sdw_ctrl_bench.sv
`timescale 1ns/1ps
module sdw_ctrl_bench;

   localparam int BL     = 4;
   localparam int DQ_W   = 16;
   localparam int NREQ   = 10;
   localparam int NEXP   = 21;
   localparam logic [2:0] C_NOP = 3'b111;
   localparam logic [2:0] C_ACT = 3'b011;
   localparam logic [2:0] C_WR  = 3'b100;
   localparam logic [2:0] C_PRE = 3'b010;

   // {bank[2], row[12], col[9], auto_pre[1]}
   localparam logic [23:0] REQ [NREQ] = '{
      {2'd0, 12'd5, 9'h008, 1'b0},
      {2'd0, 12'd5, 9'h010, 1'b0},
      {2'd1, 12'd7, 9'h020, 1'b1},
      {2'd0, 12'd9, 9'h004, 1'b0},
      {2'd0, 12'd3, 9'h008, 1'b1},
      {2'd0, 12'd3, 9'h030, 1'b0},
      {2'd1, 12'd7, 9'h03c, 1'b0},
      {2'd2, 12'd1, 9'h001, 1'b1},
      {2'd3, 12'd2, 9'h002, 1'b1},
      {2'd2, 12'd1, 9'h003, 1'b0}
   };

   // {offset from first ACT[8], cmd[3], bank[2], addr[12]}
   localparam logic [24:0] EXP [NEXP] = '{
      {8'd0,  C_ACT, 2'd0, 12'h005},
      {8'd2,  C_WR,  2'd0, 12'h008},
      {8'd6,  C_WR,  2'd0, 12'h010},
      {8'd7,  C_ACT, 2'd1, 12'h007},
      {8'd10, C_WR,  2'd1, 12'h420},
      {8'd11, C_PRE, 2'd0, 12'h000},
      {8'd13, C_ACT, 2'd0, 12'h009},
      {8'd15, C_WR,  2'd0, 12'h004},
      {8'd19, C_PRE, 2'd0, 12'h000},
      {8'd21, C_ACT, 2'd0, 12'h003},
      {8'd23, C_WR,  2'd0, 12'h408},
      {8'd29, C_ACT, 2'd0, 12'h003},
      {8'd31, C_WR,  2'd0, 12'h030},
      {8'd32, C_ACT, 2'd1, 12'h007},
      {8'd35, C_WR,  2'd1, 12'h03c},
      {8'd36, C_ACT, 2'd2, 12'h001},
      {8'd39, C_WR,  2'd2, 12'h401},
      {8'd40, C_ACT, 2'd3, 12'h002},
      {8'd43, C_WR,  2'd3, 12'h402},
      {8'd45, C_ACT, 2'd2, 12'h001},
      {8'd47, C_WR,  2'd2, 12'h003}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [1:0]        req_bank = '0;
   logic [11:0]       req_row = '0;
   logic [8:0]        req_col = '0;
   logic              req_auto_pre = 1'b0;
   logic [BL*DQ_W-1:0] req_data = '0;
   logic [2:0]        cmd_o;
   logic [1:0]        ba_o;
   logic [11:0]       addr_o;
   logic [DQ_W-1:0]   dq_o;
   logic              dq_oe;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   int eidx = 0;
   int t0 = 0;
   int wr_seen = 0;
   int beat = 0;
   int rem = 0;
   int hs = 0;
   bit mon_en = 1'b0;
   bit done = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sdw_ctrl u_sdw_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .req_bank     (req_bank),
      .req_row      (req_row),
      .req_col      (req_col),
      .req_auto_pre (req_auto_pre),
      .req_data     (req_data),
      .cmd_o        (cmd_o),
      .ba_o         (ba_o),
      .addr_o       (addr_o),
      .dq_o         (dq_o),
      .dq_oe        (dq_oe)
   );

   function automatic logic [DQ_W-1:0] word_of(int i, int k);
      return 16'hA000 | 16'(i << 4) | 16'(k);
   endfunction

   function automatic string tag_of(int e);
      case (e)
         0, 1:               return "R3";
         2:                  return "R6";
         4, 10, 16:          return "R5";
         5, 6, 7, 8, 9:      return "R7";
         11, 12, 19, 20:     return "R8";
         default:            return "R9";
      endcase
   endfunction

   task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Trace monitor: compares every command and data beat at the falling edge.
   always @(negedge clk) begin
      if (mon_en && rst_n) begin
         if (cmd_o != C_NOP) begin
            if (eidx >= NEXP) begin
               check(1'b0, "R10", "extra command", 32'(cmd_o), 32'(C_NOP));
            end else begin
               logic [24:0] e;
               e = EXP[eidx];
               if (eidx == 0) t0 = cyc;
               check(cmd_o == e[16:14], tag_of(eidx), "R2 command code", 32'(cmd_o), 32'(e[16:14]));
               check(ba_o == e[13:12] && addr_o == e[11:0], tag_of(eidx), "bank/address",
                     {18'd0, ba_o, addr_o}, {18'd0, e[13:0]});
               check((cyc - t0) == int'(e[24:17]), tag_of(eidx), "command cycle",
                     32'(cyc - t0), 32'(e[24:17]));
               eidx++;
            end
            if (cmd_o == C_WR) begin
               rem = BL;
               beat = 0;
               wr_seen++;
            end
         end
         check(dq_oe == (rem > 0), "R10", "dq_oe window", 32'(dq_oe), 32'(rem > 0));
         if (rem > 0) begin
            check(dq_o == word_of(wr_seen - 1, beat), "R4", "data beat",
                  32'(dq_o), 32'(word_of(wr_seen - 1, beat)));
            beat++;
            rem--;
         end else begin
            check(dq_o == '0, "R10", "idle dq", 32'(dq_o), 32'h0);
         end
      end
   end

   task automatic load_req(int i);
      logic [23:0] r;
      r = REQ[i];
      req_bank     = r[23:22];
      req_row      = r[21:10];
      req_col      = r[9:1];
      req_auto_pre = r[0];
      for (int k = 0; k < BL; k++) req_data[k*DQ_W +: DQ_W] = word_of(i, k);
      req_valid = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      check(1'b0, "R11", "watchdog expired", 32'(cyc), 32'd0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(cmd_o == C_NOP, "R1", "cmd during reset", 32'(cmd_o), 32'(C_NOP));
      check(dq_oe == 1'b0, "R1", "dq_oe during reset", 32'(dq_oe), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(cmd_o == C_NOP && req_ready == 1'b0, "R1", "after reset", {29'd0, cmd_o}, 32'(C_NOP));
      mon_en = 1'b1;

      // Table walk: requests back to back.
      for (int i = 0; i < NREQ; i++) begin
         load_req(i);
         #1;
         while (!req_ready) begin
            @(negedge clk);
            #1;
         end
         @(negedge clk);
         hs++;
      end
      req_valid = 1'b0;
      repeat (BL + 4) @(negedge clk);
      check(eidx == NEXP, "R10", "command count", 32'(eidx), 32'(NEXP));
      check(hs == NREQ, "R11", "accepted requests", 32'(hs), 32'(NREQ));
      mon_en = 1'b0;

      // Directed: reset mid-life closes banks (bank0 had row 3 open).
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check(cmd_o == C_NOP && dq_oe == 1'b0, "R1", "second reset", {28'd0, dq_oe, cmd_o}, 32'(C_NOP));
      rst_n = 1'b1;
      @(negedge clk);
      load_req(0);
      req_row = 12'd3;
      req_col = 9'h005;
      #1;
      check(req_ready == 1'b0, "R11", "stalled ready c0", 32'(req_ready), 32'd0);
      @(negedge clk);
      #1;
      check(cmd_o == C_ACT && addr_o == 12'd3, "R1", "ACT after reset", {17'd0, cmd_o, addr_o}, {17'd0, C_ACT, 12'd3});
      check(req_ready == 1'b0, "R11", "stalled ready c1", 32'(req_ready), 32'd0);
      @(negedge clk);
      #1;
      check(req_ready == 1'b1, "R3", "ready after T_RCD", 32'(req_ready), 32'd1);
      @(negedge clk);
      req_valid = 1'b0;
      check(cmd_o == C_WR && addr_o == 12'h005, "R5", "directed write", {17'd0, cmd_o, addr_o}, {17'd0, C_WR, 12'h005});
      check(dq_oe == 1'b1 && dq_o == word_of(0, 0), "R4", "directed beat0", 32'(dq_o), 32'(word_of(0, 0)));
      repeat (BL - 1) @(negedge clk);
      check(dq_o == word_of(0, BL - 1), "R4", "directed last beat", 32'(dq_o), 32'(word_of(0, BL - 1)));
      @(negedge clk);
      check(dq_oe == 1'b0 && cmd_o == C_NOP, "R10", "idle after burst", {28'd0, dq_oe, cmd_o}, 32'(C_NOP));

      finish_run();
   end

endmodule